// File: doc/BRIEF.md
# Hybrid Rate-Multiplier Pulse Modulator for Tuning Voltage

This block turns a 13-bit tuning code into one active-low drive line. The line switches an external transistor to ground, and an RC filter with a varicap buffer smooths it into a DC tuning voltage. Over each frame, the number of clocks the line spends low equals the code exactly. The average duty cycle is therefore proportional to the code.

A frame has 8192 enabled clocks, split into 256 slots of 32 clocks each. For small codes the block adds one-clock pulses, one per slot, until every slot carries a pulse. For larger codes the pulse count stays at 256 and each pulse gets wider. A pulse starts at the beginning of its slot. Every slot has the base width `code / 256`. The leftover `code mod 256` clocks go one each to the slots whose bit-reversed index is below that remainder, so the extra clocks are spread evenly over the frame.

The clock enable sets the modulation rate. The block reads the tuning code only at frame boundaries, so the search logic upstream can change it at any time without producing a corrupt frame.

Top module: `tune_pwm`

## Requirements
- R1: While `rst_ni` is low, `tune_n_o` is high (switch off), the frame position is zero and the active code is zero. The first frame after reset is therefore fully off.
- R2: In every frame of 8192 enabled clocks, the number of enabled clocks with `tune_n_o` low equals the active code exactly.
- R3: An active code of 0 keeps `tune_n_o` high for the whole frame.
- R4: For active codes 1 to 255, the frame contains exactly that many separate low pulses, each one clock wide and each at the first clock of a slot.
- R5: For active codes 256 to 7935, the frame contains exactly 256 low pulses, one starting at the first clock of each 32-clock slot.
- R6: Slot s (0..255, in frame order) is low for `code>>8` clocks, plus one more clock when the 8-bit reversal of s is less than `code[7:0]`. The low clocks come first in the slot.
- R7: A change on `code_i` during a frame has no effect on that frame. The new value becomes active at the next frame boundary.
- R8: While `en_i` is low, the frame position and `tune_n_o` hold their values. A frame counts only enabled clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; advances the frame by one step |
| code_i | input | 13 | Tuning code, read at frame boundaries |
| tune_n_o | output | 1 | Registered drive, low = switch conducts |

## Verification
The codes tested are 0, 1, 255, 256, 257, 300, 4096, 4097, 6000, 7935 and 8191. Together they cover:
- the pure rate-multiplier range;
- the point where the pulse count saturates;
- remainders that do and do not need spreading;
- the top of the range, where pulses nearly merge.

For each frame the bench compares three things against values derived from the code: the total low time, the pulse count, and every slot's width. Slot widths are what separate a correct bit-reversed spreading from any other ordering. The code input is changed in the middle of every frame, so each frame also shows that only the code held at the boundary counts. One frame is run with the enable toggling, which shows that the output holds while the enable is low and that the count is taken in enabled clocks.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int unsigned CODE_W_DEF = 13;  // tuning resolution
  localparam int unsigned SLOT_W_DEF = 5;   // log2 clocks per slot
endpackage

// File: rtl/tpm_frame_ctr.sv
module tpm_frame_ctr #(
  parameter int unsigned CODE_W = tpm_pkg::CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [CODE_W-1:0] cnt_o,
  output logic              last_o
);
  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = &cnt_q;

  // R2
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && last_o) |=> (cnt_o == '0));
  // R8
  ctr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o));
endmodule

// File: rtl/tpm_slot_width.sv
module tpm_slot_width #(
  parameter int unsigned CODE_W = tpm_pkg::CODE_W_DEF,
  parameter int unsigned SLOT_W = tpm_pkg::SLOT_W_DEF,
  localparam int unsigned NSLOT_W = CODE_W - SLOT_W
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic [NSLOT_W-1:0] slot_i,
  output logic [SLOT_W:0]    width_o
);
  logic [NSLOT_W-1:0] slot_rev;
  logic [SLOT_W-1:0]  base;
  logic [NSLOT_W-1:0] rem;
  logic               extra;

  for (genvar b = 0; b < NSLOT_W; b++) begin : g_rev
    assign slot_rev[b] = slot_i[NSLOT_W-1-b];
  end

  assign base    = code_i[CODE_W-1:NSLOT_W];
  assign rem     = code_i[NSLOT_W-1:0];
  // bit-reversed slot index spreads the remainder evenly across the frame
  assign extra   = (slot_rev < rem);
  assign width_o = {1'b0, base} + {{SLOT_W{1'b0}}, extra};
endmodule

// File: rtl/tpm_pulse_gen.sv
module tpm_pulse_gen #(
  parameter int unsigned SLOT_W = tpm_pkg::SLOT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SLOT_W-1:0] phase_i,
  input  logic [SLOT_W:0]   width_i,
  output logic              drv_n_o
);
  logic drv_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   drv_n_q <= 1'b1;
    else if (en_i) drv_n_q <= !({1'b0, phase_i} < width_i);
  end

  assign drv_n_o = drv_n_q;

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(drv_n_o));
endmodule

// File: rtl/tune_pwm.sv
module tune_pwm #(
  parameter int unsigned CODE_W = tpm_pkg::CODE_W_DEF,
  parameter int unsigned SLOT_W = tpm_pkg::SLOT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tune_n_o
);
  localparam int unsigned NSLOT_W = CODE_W - SLOT_W;
  localparam int unsigned NSLOT   = 1 << NSLOT_W;

  logic [CODE_W-1:0] cnt;
  logic              last;
  logic [CODE_W-1:0] code_q;
  logic [SLOT_W:0]   width;

  tpm_frame_ctr #(.CODE_W(CODE_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .cnt_o (cnt),
    .last_o(last)
  );

  // new code only at the frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           code_q <= '0;
    else if (en_i && last) code_q <= code_i;
  end

  tpm_slot_width #(.CODE_W(CODE_W), .SLOT_W(SLOT_W)) u_width (
    .code_i (code_q),
    .slot_i (cnt[CODE_W-1:SLOT_W]),
    .width_o(width)
  );

  tpm_pulse_gen #(.SLOT_W(SLOT_W)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .phase_i(cnt[SLOT_W-1:0]),
    .width_i(width),
    .drv_n_o(tune_n_o)
  );

  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && last) |=> $stable(code_q));
  // R3
  zero_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && code_q == '0) |=> tune_n_o);
  // R4
  narrow_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && code_q < CODE_W'(NSLOT) && cnt[SLOT_W-1:0] != '0) |=> tune_n_o);
endmodule

// File: tb/tune_pwm_bench.sv
module tune_pwm_bench;
  localparam int FRAME = 8192;
  localparam int NV    = 11;
  localparam int VEC [NV] = '{1, 255, 256, 257, 300, 4096, 4097, 7935, 8191, 0, 6000};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic [12:0] code_i = 13'd5000;
  logic        tune_n_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic prev_out = 1'b1;

  always #2.5 clk_i = ~clk_i;

  tune_pwm u_tune_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .code_i(code_i), .tune_n_o(tune_n_o)
  );

  function automatic int rev8(input int s);
    int r = 0;
    for (int b = 0; b < 8; b++) if (s[b]) r |= (1 << (7 - b));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one frame checking exp_code; code_i changes mid-frame to next_code
  task automatic run_frame(input int exp_code, input int next_code, input bit gated);
    int lows = 0, runs = 0, slot_bad = 0, slot_low = 0, stall_bad = 0, exp_w;
    for (int i = 0; i < FRAME; i++) begin
      if (gated) begin
        en_i = 1'b0;
        @(negedge clk_i);
        if (tune_n_o !== prev_out) stall_bad++;
        en_i = 1'b1;
      end
      @(negedge clk_i);
      if (i == FRAME/2) code_i = 13'(next_code);
      if (!tune_n_o) begin
        lows++;
        slot_low++;
        if (prev_out) runs++;
      end
      prev_out = tune_n_o;
      if (i % 32 == 31) begin
        exp_w = (exp_code >> 8) + ((rev8(i / 32) < (exp_code & 255)) ? 1 : 0);
        if (slot_low != exp_w) slot_bad++;
        slot_low = 0;
      end
    end
    if (exp_code == 0) chk(lows == 0, "R3 R7 low clocks", lows, 0);
    else               chk(lows == exp_code, "R2 R7 low clocks", lows, exp_code);
    chk(slot_bad == 0, "R6 slot widths bad", slot_bad, 0);
    if (exp_code < 256)       chk(runs == exp_code, "R4 pulse count", runs, exp_code);
    else if (exp_code < 7936) chk(runs == 256, "R5 pulse count", runs, 256);
    if (gated) chk(stall_bad == 0, "R8 output moved while disabled", stall_bad, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(tune_n_o === 1'b1, "R1 output during reset", tune_n_o, 1);
    rst_ni = 1'b1;
    // first frame after reset: active code is zero although code_i=5000
    run_frame(0, VEC[0], 1'b0);
    for (int j = 1; j < NV; j++) run_frame(VEC[j-1], VEC[j], 1'b0);
    run_frame(VEC[NV-1], 3000, 1'b0);
    // R8: enable toggling, frame counted in enabled clocks
    run_frame(3000, 100, 1'b1);
    // R1: async reset forces the switch off
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(tune_n_o === 1'b1, "R1 output after async reset", tune_n_o, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule